// File: doc/BRIEF.md
# External Interrupt Trigger Detector

This block sits between eight external interrupt pins and the request logic of an interrupt controller. Each pin is brought into the clock domain through two flip-flops. A per-pin 2-bit mode then selects how the pin is interpreted. In the two level modes the output follows the pin's active level. In the two edge modes the output gives a one-cycle strobe for each qualifying transition.

Output bit `k` feeds external interrupt group `23 + k`, so pins 0..3 drive groups 23..26 and pins 4..7 drive groups 27..30. The modes are held in two byte-wide registers behind a simple byte port. Writes are strobed, and reads return data combinationally from the current address.

Top module: `ext_irq_detect`

## Requirements
- R1: After reset every pin is in falling-edge mode (mode 3), so mode bytes 0 and 1 both read 0xFF. No edge strobe appears while the synchronised pins and their previous values are still in their reset state.
- R2: Mode byte 0 holds pins 0..3 and byte 1 holds pins 4..7. Within a byte, pin n of that byte sits at bits [2n+1:2n]. A write with `cfg_wr` high updates the byte on the next rising clock edge, and a read at the same address returns it.
- R3: Mode 0 (active low): `irq_req[k]` is high exactly while the synchronised pin is 0. A pin change shows at the output after the second rising clock edge that samples the new value.
- R4: Mode 1 (active high): `irq_req[k]` is high exactly while the synchronised pin is 1, with the same two-edge latency.
- R5: Mode 2 (rising edge): each 0-to-1 transition of the synchronised pin gives a request that lasts exactly one cycle.
- R6: Mode 3 (falling edge): each 1-to-0 transition of the synchronised pin gives a request that lasts exactly one cycle.
- R7: Addresses 2 and above read as 0x00. Writes to them change no mode.
- R8: A mode write never creates an edge strobe on a pin whose synchronised value is steady. The output is always evaluated with the mode held in the register during that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_pin | input | 8 | Asynchronous external interrupt pins |
| cfg_addr | input | 2 | Mode byte address |
| cfg_wr | input | 1 | Write strobe for the mode byte at `cfg_addr` |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Read data for `cfg_addr` |
| irq_req | output | 8 | Request to group 23+k for pin k |

## Verification
Two events can land on the same clock edge: a mode write and a transition moving into the second synchroniser stage. Either can also coincide with a transition that has already been sampled. The bench provokes these overlaps by toggling pins at random while it issues frequent writes to random addresses with random data, so mode changes regularly meet fresh edges and steady pins. For every cycle, a bench model of the pin pipeline and the mode bytes predicts each output bit under the mode just written. The check is tagged to the mode rule that applied, or to R8 when a write preceded it.

// File: rtl/ext_irq_detect.sv
module ext_irq_detect #(
  parameter int NUM_BYTES     = 2,
  parameter int PINS_PER_BYTE = 4,
  parameter int ADDR_W        = 2
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic [NUM_BYTES*PINS_PER_BYTE-1:0]   ext_pin,
  input  logic [ADDR_W-1:0]                    cfg_addr,
  input  logic                                 cfg_wr,
  input  logic [2*PINS_PER_BYTE-1:0]           cfg_wdata,
  output logic [2*PINS_PER_BYTE-1:0]           cfg_rdata,
  output logic [NUM_BYTES*PINS_PER_BYTE-1:0]   irq_req
);
  localparam int NUM_PINS = NUM_BYTES * PINS_PER_BYTE;
  localparam logic [1:0] M_LOW  = 2'd0;
  localparam logic [1:0] M_HIGH = 2'd1;
  localparam logic [1:0] M_RISE = 2'd2;
  localparam logic [1:0] M_FALL = 2'd3;

  logic [NUM_PINS-1:0] meta_q, sync_q, prev_q;
  logic [1:0]          mode_q [NUM_PINS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= ext_pin;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    localparam int BYTE = i / PINS_PER_BYTE;
    localparam int SLOT = i % PINS_PER_BYTE;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        mode_q[i] <= M_FALL;
      else if (cfg_wr && cfg_addr == ADDR_W'(BYTE))
        mode_q[i] <= cfg_wdata[2*SLOT +: 2];
    end

    always_comb begin
      unique case (mode_q[i])
        M_LOW:   irq_req[i] = ~sync_q[i];
        M_HIGH:  irq_req[i] =  sync_q[i];
        M_RISE:  irq_req[i] =  sync_q[i] & ~prev_q[i];
        default: irq_req[i] = ~sync_q[i] &  prev_q[i];
      endcase
    end

    AST_EDGE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q[i][1] && irq_req[i]) |=> (mode_q[i] != $past(mode_q[i]) || !irq_req[i])) // R5
      else $error("edge request held for more than one cycle on pin %0d", i);
    AST_RISE_FROM_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q[i] == M_RISE && irq_req[i]) |-> $past(meta_q[i])) // R5
      else $error("rising request without high sample on pin %0d", i);
    AST_LOW_FROM_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q[i] == M_LOW && irq_req[i]) |-> !$past(meta_q[i])) // R3
      else $error("active-low request without low sample on pin %0d", i);
    AST_WRITE_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr && meta_q[i] == sync_q[i]) |=> !(mode_q[i][1] && irq_req[i])) // R8
      else $error("mode write produced an edge strobe on pin %0d", i);
  end

  always_comb begin
    cfg_rdata = '0;
    for (int b = 0; b < NUM_BYTES; b++)
      if (cfg_addr == ADDR_W'(b))
        for (int n = 0; n < PINS_PER_BYTE; n++)
          cfg_rdata[2*n +: 2] = mode_q[b*PINS_PER_BYTE + n];
  end

  AST_HIGH_ADDR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(cfg_addr) >= NUM_BYTES) |-> cfg_rdata == '0) // R7
    else $error("unmapped address returned nonzero data");
  AST_HIGH_ADDR_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && int'(cfg_addr) >= NUM_BYTES) |=> (mode_q[0] == $past(mode_q[0]) &&
      mode_q[NUM_PINS-1] == $past(mode_q[NUM_PINS-1]))) // R7
    else $error("write to unmapped address changed a mode");
endmodule

// File: tb/ext_irq_detect_bench.sv
module ext_irq_detect_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] ext_pin = 8'hFF;
  logic [1:0] cfg_addr = '0;
  logic       cfg_wr = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] cfg_rdata;
  logic [7:0] irq_req;

  int checks = 0;
  int fails  = 0;

  logic [7:0] m_s1 = '0, m_s2 = '0, m_prev = '0;
  logic [1:0] m_mode [NP];
  logic       last_wr = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ext_irq_detect u_ext_irq_detect (
    .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .cfg_addr(cfg_addr),
    .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .irq_req(irq_req)
  );

  function automatic logic exp_req(int k);
    case (m_mode[k])
      2'd0: return !m_s2[k];
      2'd1: return  m_s2[k];
      2'd2: return  m_s2[k] && !m_prev[k];
      default: return !m_s2[k] && m_prev[k];
    endcase
  endfunction

  function automatic logic [7:0] exp_rdata(logic [1:0] a);
    logic [7:0] v = '0;
    if (a < 2)
      for (int n = 0; n < 4; n++) v[2*n +: 2] = m_mode[a*4 + n];
    return v;
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_outputs();
    for (int k = 0; k < NP; k++) begin
      string tag;
      if (last_wr && m_mode[k][1]) tag = "R8";
      else case (m_mode[k])
        2'd0: tag = "R3";
        2'd1: tag = "R4";
        2'd2: tag = "R5";
        default: tag = "R6";
      endcase
      check(tag, {7'd0, irq_req[k]}, {7'd0, exp_req(k)});
    end
    check(cfg_addr >= 2 ? "R7" : "R2", cfg_rdata, exp_rdata(cfg_addr));
  endtask

  task automatic step(logic [7:0] pins, logic wr, logic [1:0] a, logic [7:0] d);
    ext_pin = pins; cfg_wr = wr; cfg_addr = a; cfg_wdata = d;
    @(posedge clk);
    m_prev = m_s2; m_s2 = m_s1; m_s1 = pins;
    if (wr && a < 2)
      for (int n = 0; n < 4; n++) m_mode[a*4 + n] = d[2*n +: 2];
    last_wr = wr;
    @(negedge clk);
    check_outputs();
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] pins;
    void'($urandom(32'h1A2B3C));
    for (int k = 0; k < NP; k++) m_mode[k] = 2'd3;
    repeat (3) @(negedge clk);
    check("R1", irq_req, 8'h00);
    cfg_addr = 2'd0; #1 check("R1", cfg_rdata, 8'hFF);
    cfg_addr = 2'd1; #1 check("R1", cfg_rdata, 8'hFF);
    @(negedge clk);
    rst_n = 1'b1;
    pins = 8'hFF;
    step(pins, 1'b0, 2'd0, 8'h00);
    step(pins, 1'b0, 2'd1, 8'h00);
    // R6: fall on pin 0, R5 setup via mode bytes, R2 packing
    step(8'hFE, 1'b1, 2'd1, 8'b10_01_00_11);
    step(8'hFE, 1'b0, 2'd1, 8'h00);
    step(8'hFE, 1'b0, 2'd0, 8'h00);
    // R8: mode flips to edge on steady pins
    step(8'hFE, 1'b1, 2'd0, 8'b10_11_10_11);
    step(8'hFE, 1'b1, 2'd0, 8'b11_10_11_10);
    // R7: writes to unmapped addresses
    step(8'hFE, 1'b1, 2'd2, 8'h00);
    step(8'hFE, 1'b1, 2'd3, 8'h55);
    step(8'hFE, 1'b0, 2'd3, 8'h00);
    // R3 R4: level modes across toggles
    step(8'hFE, 1'b1, 2'd0, 8'b00_01_00_01);
    step(8'h0F, 1'b0, 2'd0, 8'h00);
    step(8'h0F, 1'b0, 2'd0, 8'h00);
    step(8'hF0, 1'b0, 2'd1, 8'h00);
    step(8'hF0, 1'b0, 2'd0, 8'h00);
    pins = 8'hF0;
    for (int c = 0; c < 4000; c++) begin
      for (int k = 0; k < NP; k++)
        if ($urandom % 5 == 0) pins[k] = ~pins[k];
      step(pins, ($urandom % 6) == 0, 2'($urandom), 8'($urandom));
    end
    finish_run();
  end
endmodule